// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side protocol engine of a 1024-byte serial EEPROM on a two-wire bus. It runs on a fast system clock and oversamples the bus clock and data lines through synchronizer flops. It drives the data line only low, through an output-enable. It recognises start and stop conditions and checks the select byte against a strap pin. It then runs byte writes, page writes, current reads, random reads and sequential reads against an internal synchronous byte array.

Write data is held in a page buffer and reaches the array only when a stop condition ends the command. At that point the engine emits a one-cycle pulse that an external write-cycle timer uses to start its busy period. While that timer reports busy, or while the buffer is still being copied into the array, the engine ignores the bus. A master can therefore poll for the end of the write by sending select bytes until one is acknowledged.

Top module: `tw_eeprom_slave`

## Requirements
- R1: While rst_ni is low and right after it rises, sda_oe_o and wr_start_o are 0.
- R2: A select byte is acknowledged (sda_oe_o high through the ninth clock) only when its top nibble is 1010 and bit 3 equals dev_sel_i. Bits 2..1 give address bits 9..8 and bit 0 selects read (1) or write (0). Any other select byte gets no acknowledge.
- R3: In write mode the word-address byte and every data byte after it are acknowledged.
- R4: Write data goes into the array only when a stop condition ends the command. wr_start_o then pulses for exactly one cycle, and only if at least one data byte was received.
- R5: In a page write, each byte after the first goes to the next address with only the low 4 bits incremented. The address wraps inside its 16-byte page, so excess bytes overwrite earlier ones.
- R6: A random read (write select, word address, repeated start, read select) returns the byte at {select bits 2..1, word address}.
- R7: A current read after a read returns the byte one past the last byte read. A current read after a write returns the byte at the last address written.
- R8: During a read, a low acknowledge from the master sends the byte at the next address, wrapping from 0x3FF to 0x000. A high acknowledge ends transmission, and sda_oe_o stays low until the next start.
- R9: While wr_busy_i is high, or a buffered page is still being copied into the array, a matching select byte is not acknowledged.
- R10: A start condition discards any buffered write data. A start followed by a stop, or a repeated start before the stop, writes nothing and gives no wr_start_o pulse.
- R11: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel_i | input | 1 | Strap compared with select-byte bit 3 |
| wr_busy_i | input | 1 | External write-cycle timer busy flag |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| wr_start_o | output | 1 | One-cycle pulse when a buffered write is committed |

## Verification
Two decisions can meet on the same bus transaction. One is the select-byte decision, made at the falling edge that closes the eighth bit. The other is the busy state, which comes from the external timer and from the internal page copy. The bench holds wr_busy_i high across a full select byte and expects no acknowledge. It then drops the flag and expects the same select byte to be acknowledged, with the read data intact. A second collision is a repeated start that arrives while write data sits in the page buffer. There the bench expects the old array contents and no commit pulse.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign rise_o  = scl_s & ~scl_p;
  assign fall_o  = ~scl_s & scl_p;
  // data edges with the clock held high on both samples
  assign start_o = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned PAGE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     ld_i,
  input  logic [PAGE_W-1:0]        ld_idx_i,
  input  logic [ADDR_W-PAGE_W-1:0] ld_blk_i,
  input  logic [7:0]               ld_data_i,
  input  logic                     commit_i,
  output logic                     busy_o,
  output logic                     wr_start_o,
  output logic                     we_o,
  output logic [ADDR_W-1:0]        waddr_o,
  output logic [7:0]               wdata_o
);
  localparam int unsigned NB    = 1 << PAGE_W;
  localparam int unsigned BLK_W = ADDR_W - PAGE_W;

  logic [NB-1:0]     mask_q;
  logic [7:0]        data_q [NB];
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] idx_q;
  logic              active_q, wst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      blk_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      wst_q    <= 1'b0;
    end else begin
      wst_q <= 1'b0;
      if (active_q) begin
        idx_q <= idx_q + PAGE_W'(1);
        if (&idx_q) begin
          active_q <= 1'b0;
          mask_q   <= '0;
        end
      end else if (commit_i && |mask_q) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        wst_q    <= 1'b1;
      end else if (clr_i) begin
        mask_q <= '0;
      end else if (ld_i) begin
        mask_q[ld_idx_i] <= 1'b1;
        blk_q            <= ld_blk_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_i && !active_q) data_q[ld_idx_i] <= ld_data_i;
  end

  assign busy_o     = active_q;
  assign wr_start_o = wst_q;
  assign we_o       = active_q & mask_q[idx_q];
  assign waddr_o    = {blk_q, idx_q};
  assign wdata_o    = data_q[idx_q];
endmodule

// File: rtl/tw_byte_mem.sv
module tw_byte_mem #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic dev_sel_i,
  input  logic wr_busy_i,
  output logic sda_oe_o,
  output logic wr_start_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_ev),
    .stop_o  (stop_ev)
  );

  tw_state_e         state_q, nxt_q;
  logic [3:0]        bitc_q;
  logic [7:0]        sh_q, tx_q;
  logic [ADDR_W-1:0] ptr_q, rd_addr_q;
  logic [HI_W-1:0]   page_q;
  logic              oe_q, rd_last_q, got_q, mack_q, ack_sel_q;
  logic              rd_req_q, rd_pend_q;

  logic              pb_busy, pb_we, pb_ld;
  logic [ADDR_W-1:0] pb_waddr;
  logic [7:0]        pb_wdata, mem_rdata;
  logic              busy, byte_done, sel_ok;
  logic [ADDR_W-1:0] rd_first, wa_nxt;

  assign busy      = wr_busy_i | pb_busy;
  assign byte_done = scl_fall && (bitc_q == 4'd8);
  assign sel_ok    = (sh_q[7:4] == DEV_TYPE) && (sh_q[3] == dev_sel_i) && !busy;
  assign rd_first  = rd_last_q ? ptr_q + ADDR_W'(1) : ptr_q;
  assign wa_nxt    = got_q ? {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)} : ptr_q;
  assign pb_ld     = (state_q == ST_WDATA) && byte_done && !start_ev && !stop_ev;

  tw_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_pbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_ev),
    .ld_i       (pb_ld),
    .ld_idx_i   (wa_nxt[PAGE_W-1:0]),
    .ld_blk_i   (wa_nxt[ADDR_W-1:PAGE_W]),
    .ld_data_i  (sh_q),
    .commit_i   (stop_ev),
    .busy_o     (pb_busy),
    .wr_start_o (wr_start_o),
    .we_o       (pb_we),
    .waddr_o    (pb_waddr),
    .wdata_o    (pb_wdata)
  );

  tw_byte_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (pb_we),
    .waddr_i (pb_waddr),
    .wdata_i (pb_wdata),
    .re_i    (rd_req_q),
    .raddr_i (rd_addr_q),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bitc_q    <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rd_addr_q <= '0;
      page_q    <= '0;
      oe_q      <= 1'b0;
      rd_last_q <= 1'b0;
      got_q     <= 1'b0;
      mack_q    <= 1'b0;
      ack_sel_q <= 1'b0;
      rd_req_q  <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_req_q  <= 1'b0;
      rd_pend_q <= rd_req_q;
      if (rd_pend_q) tx_q <= mem_rdata;

      if (start_ev) begin
        state_q   <= ST_DEV;
        bitc_q    <= '0;
        oe_q      <= 1'b0;
        ack_sel_q <= 1'b0;
      end else if (stop_ev) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        ack_sel_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q   <= {sh_q[6:0], sda_s};
              bitc_q <= bitc_q + 4'd1;
            end else if (byte_done) begin
              bitc_q <= '0;
              if (state_q == ST_DEV) begin
                if (sel_ok) begin
                  oe_q      <= 1'b1;
                  ack_sel_q <= 1'b1;
                  state_q   <= ST_ACK;
                  if (sh_q[0]) begin
                    nxt_q     <= ST_TX;
                    rd_req_q  <= 1'b1;
                    rd_addr_q <= rd_first;
                    ptr_q     <= rd_first;
                    rd_last_q <= 1'b1;
                  end else begin
                    nxt_q  <= ST_ADDR;
                    page_q <= sh_q[HI_W:1];
                  end
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_ADDR) begin
                ptr_q     <= {page_q, sh_q};
                rd_last_q <= 1'b0;
                got_q     <= 1'b0;
                oe_q      <= 1'b1;
                nxt_q     <= ST_WDATA;
                state_q   <= ST_ACK;
              end else begin
                ptr_q   <= wa_nxt;
                got_q   <= 1'b1;
                oe_q    <= 1'b1;
                nxt_q   <= ST_WDATA;
                state_q <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state_q   <= nxt_q;
              bitc_q    <= '0;
              ack_sel_q <= 1'b0;
              oe_q      <= (nxt_q == ST_TX) ? ~tx_q[7] : 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitc_q <= bitc_q + 4'd1;
            end else if (scl_fall) begin
              if (bitc_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                oe_q <= ~tx_q[6];
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s) begin
                rd_req_q  <= 1'b1;
                rd_addr_q <= ptr_q + ADDR_W'(1);
                ptr_q     <= ptr_q + ADDR_W'(1);
              end
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_TX;
                bitc_q  <= '0;
                oe_q    <= ~tx_q[7];
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
  import tw_eeprom_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      scl_i,
  input logic      wr_busy_i,
  input logic      sda_oe_o,
  input logic      wr_start_o,
  input logic      pb_busy,
  input logic      ack_sel,
  input logic      stop_ev,
  input tw_state_e state
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o)); // R11

  AST_WSTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> !wr_start_o); // R4

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pb_busy) |-> $past(stop_ev)); // R4

  AST_SEL_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_sel) |-> $past(!wr_busy_i && !pb_busy)); // R9

  AST_QUIET_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe_o); // R8
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .wr_busy_i  (wr_busy_i),
  .sda_oe_o   (sda_oe_o),
  .wr_start_o (wr_start_o),
  .pb_busy    (pb_busy),
  .ack_sel    (ack_sel_q),
  .stop_ev    (stop_ev),
  .state      (state_q)
);

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int WDOG       = 150000;
  localparam logic DEV      = 1'b1;
  localparam int NVEC       = 6;
  // {word address[9:0], data[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {10'h001, 8'h3C}, {10'h0FF, 8'h81}, {10'h100, 8'h7E},
    {10'h2AA, 8'h55}, {10'h37F, 8'h00}, {10'h155, 8'hE7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_line, sda_oe, wr_start;
  int   n_chk = 0, n_fail = 0, n_wst = 0, n_viol = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  tw_eeprom_slave u_tw_eeprom_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .dev_sel_i  (DEV),
    .wr_busy_i  (wr_busy),
    .sda_oe_o   (sda_oe),
    .wr_start_o (wr_start)
  );

  always @(negedge clk) begin
    if (rst_n && wr_start) n_wst++;
    if (rst_n && sda_oe !== oe_prev && m_scl && scl_prev) n_viol++;
    oe_prev  <= sda_oe;
    scl_prev <= m_scl;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel_b(input logic rw, input logic [1:0] hi, input logic dv);
    return {4'b1010, dv, hi, rw};
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0;
    end
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); ack = !sda_line; q(); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q(); b[i] = sda_line; q(); m_scl = 1'b0;
    end
    m_sda = nack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic write_seq(input logic [9:0] a, input int n, output logic ok_sel, output logic ok_rest);
    logic ak;
    bus_start();
    send_byte(sel_b(1'b0, a[9:8], DEV), ok_sel);
    send_byte(a[7:0], ak); ok_rest = ak;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); ok_rest &= ak;
    end
    bus_stop();
    repeat (40) @(negedge clk);
  endtask

  task automatic read_seq(input logic [9:0] a, input int n, output logic ok);
    logic ak;
    bus_start();
    send_byte(sel_b(1'b0, a[9:8], DEV), ak); ok = ak;
    send_byte(a[7:0], ak); ok &= ak;
    bus_start();
    send_byte(sel_b(1'b1, 2'b00, DEV), ak); ok &= ak;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    bus_stop();
    repeat (10) @(negedge clk);
  endtask

  task automatic cur_read(output logic ok);
    bus_start();
    send_byte(sel_b(1'b1, 2'b00, DEV), ok);
    recv_byte(1'b1, rbuf[0]);
    bus_stop();
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    check("R11 oe change while SCL high", n_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic s_ok, r_ok, ok;
    int wst0;
    repeat (4) @(negedge clk);
    check("R1 oe in reset", sda_oe, 0);
    check("R1 wr_start in reset", wr_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", sda_oe, 0);
    check("R1 wr_start after reset", wr_start, 0);

    // table walk: byte write then random read of each vector
    for (int v = 0; v < NVEC; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_seq(VEC[v][17:8], 1, s_ok, r_ok);
      check("R2 select ack", s_ok, 1);
      check("R3 addr/data ack", r_ok, 1);
      read_seq(VEC[v][17:8], 1, ok);
      check("R6 random read ack", ok, 1);
      check("R6 random read data", rbuf[0], VEC[v][7:0]);
    end
    check("R4 one commit pulse per write", n_wst, NVEC);

    // R2 mismatching device bit and device type
    bus_start(); send_byte(sel_b(1'b1, 2'b00, ~DEV), ok); bus_stop();
    check("R2 wrong device bit nack", ok, 0);
    bus_start(); send_byte(8'b1011_1001, ok); bus_stop();
    check("R2 wrong type nack", ok, 0);

    // R5 page wrap inside 16-byte page
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_seq(10'h13E, 4, s_ok, r_ok);
    read_seq(10'h13E, 2, ok);
    check("R5 page byte 13E", rbuf[0], 8'hC0);
    check("R5 page byte 13F", rbuf[1], 8'hC1);
    read_seq(10'h130, 2, ok);
    check("R5 wrapped byte 130", rbuf[0], 8'hC2);
    check("R5 wrapped byte 131", rbuf[1], 8'hC3);
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
    write_seq(10'h200, 18, s_ok, r_ok);
    check("R3 long page acks", r_ok, 1);
    read_seq(10'h200, 3, ok);
    check("R5 overwrite 200", rbuf[0], 8'h50);
    check("R5 overwrite 201", rbuf[1], 8'h51);
    check("R5 kept 202", rbuf[2], 8'h42);

    // R7 current read address rule
    wbuf[0] = 8'h66; write_seq(10'h056, 1, s_ok, r_ok);
    wbuf[0] = 8'h5A; write_seq(10'h055, 1, s_ok, r_ok);
    cur_read(ok);
    check("R7 current read after write", rbuf[0], 8'h5A);
    cur_read(ok);
    check("R7 current read after read", rbuf[0], 8'h66);

    // R8 sequential wrap and NACK termination
    wbuf[0] = 8'hA1; write_seq(10'h3FF, 1, s_ok, r_ok);
    wbuf[0] = 8'hB2; write_seq(10'h000, 1, s_ok, r_ok);
    bus_start();
    send_byte(sel_b(1'b0, 2'b11, DEV), ok);
    send_byte(8'hFF, ok);
    bus_start();
    send_byte(sel_b(1'b1, 2'b00, DEV), ok);
    recv_byte(1'b0, rbuf[0]);
    recv_byte(1'b1, rbuf[1]);
    recv_byte(1'b1, rbuf[2]);
    bus_stop();
    check("R8 sequential 3FF", rbuf[0], 8'hA1);
    check("R8 wrapped to 000", rbuf[1], 8'hB2);
    check("R8 released after nack", rbuf[2], 8'hFF);

    // R9 busy blocks select ack
    wr_busy = 1'b1;
    bus_start(); send_byte(sel_b(1'b1, 2'b00, DEV), ok); bus_stop();
    check("R9 no ack while busy", ok, 0);
    wr_busy = 1'b0;
    read_seq(10'h001, 1, ok);
    check("R9 ack after busy", ok, 1);
    check("R9 data after busy", rbuf[0], 8'h3C);

    // R10 cancellation
    wbuf[0] = 8'h22; write_seq(10'h0A0, 1, s_ok, r_ok);
    wst0 = n_wst;
    bus_start(); bus_stop();
    repeat (40) @(negedge clk);
    bus_start();
    send_byte(sel_b(1'b0, 2'b00, DEV), ok);
    send_byte(8'hA0, ok);
    send_byte(8'h33, ok);
    bus_start(); bus_stop();
    repeat (40) @(negedge clk);
    bus_start();
    send_byte(sel_b(1'b0, 2'b00, DEV), ok);
    send_byte(8'hA0, ok);
    send_byte(8'h11, ok);
    bus_start();
    send_byte(sel_b(1'b1, 2'b00, DEV), ok);
    recv_byte(1'b1, rbuf[0]);
    bus_stop();
    repeat (40) @(negedge clk);
    check("R10 repeated start discards data", rbuf[0], 8'h22);
    check("R10 no commit pulse", n_wst, wst0);
    read_seq(10'h0A0, 1, ok);
    check("R4 unchanged without stop", rbuf[0], 8'h22);

    finish_run();
  end
endmodule